// File: doc/BRIEF.md
# PLL Output Rate Calculator

This block works out the output frequency of a fractional-N PLL from the values held in its two configuration words. A caller presents a reference rate in Hz, the two words and a mode select, then pulses `start`. The block latches everything in that cycle. It builds the fixed-point product of the reference and the feedback factor with a shift-add multiplier. It then divides by the post-divider chain with a restoring shift-subtract divider and rounds the quotient to the nearest integer.

The feedback factor is an integer part plus a 16-bit fraction. The divider chain is a pre-divide multiplied by a power of two. The 2^16 fraction scale is carried into the divisor, so no fractional bits are lost before the division. In bypass mode the block returns the reference rate unchanged. If the pre-divide is zero, the block does not divide: it flags an error and reports zero. Neither of these cases uses the arithmetic units.

Top module: `pll_rate_calc`

## Requirements
- R1: Word A holds the fraction F in bits [31:16], the integer feedback N in bits [15:6] and the pre-divide D in bits [5:0]. Word B holds the power-of-two exponent E in bits [2:0]. Bits [31:3] of word B have no effect on the result.
- R2: When not bypassed and D is nonzero, `rate_hz` = floor((ref·(N·65536+F) + Q/2) / Q), where Q = D·2^E·65536. This is the nearest integer to ref·(N+F/65536)/(D·2^E), with exact halves rounded up.
- R3: With `bypass` high at start, `rate_hz` equals the latched reference and `err` is 0, even when D is zero. `done` rises 1 cycle after the start edge.
- R4: With `bypass` low and D = 0, `err` is 1 and `rate_hz` is 0. `done` rises 1 cycle after the start edge.
- R5: A rounded quotient above 2^32−1 is reported as 32'hFFFFFFFF.
- R6: In the arithmetic path, `done` rises 87 cycles after the start edge: 26 multiply steps, 59 divide steps and 2 handoff cycles.
- R7: `busy` is high from the cycle after an accepted start until the cycle before `done`, and is low while `done` is high.
- R8: `done` is a single-cycle pulse. `rate_hz` and `err` hold their values until the next completion.
- R9: `start` is ignored while `busy` is high. Inputs that change after the start edge do not alter the result.
- R10: After reset, `busy`, `done`, `err` and `rate_hz` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| bypass | input | 1 | Return the reference rate unchanged |
| ref_hz | input | 32 | Reference rate in Hz |
| cfg_a | input | 32 | Configuration word A (F, N, D) |
| cfg_b | input | 32 | Configuration word B (E in low bits) |
| rate_hz | output | 32 | Computed output rate in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero pre-divide was given |

## Verification
The bench builds the block with its default widths: a 32-bit reference, a 10-bit integer feedback with a 16-bit fraction, a 6-bit pre-divide and a 3-bit exponent. These widths make the multiplier 26 steps and the divider 59 steps. They also let the full product, up to 2^58, reach the saturation path, and they put exponents up to 7 and fractions with exact half remainders in range. Random words with garbage upper bits in word B are mixed with directed tie, saturation, zero pre-divide and bypass cases.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int REF_W  = 32;
  localparam int OUT_W  = 32;
  localparam int FRAC_W = 16;
  localparam int INT_W  = 10;
  localparam int PDV_W  = 6;
  localparam int EXP_W  = 3;
  // field positions in the configuration words
  localparam int FRAC_LSB = 16;
  localparam int INT_LSB  = 6;
  localparam int PDV_LSB  = 0;
  localparam int EXP_LSB  = 0;
  // derived widths
  localparam int MULT_W = INT_W + FRAC_W;
  localparam int DVS_W  = PDV_W + (1 << EXP_W) - 1 + FRAC_W;
  localparam int PROD_W = REF_W + MULT_W;
  localparam int DVD_W  = PROD_W + 1;

  function automatic logic [FRAC_W-1:0] get_frac(input logic [31:0] w);
    return w[FRAC_LSB +: FRAC_W];
  endfunction

  function automatic logic [INT_W-1:0] get_int(input logic [31:0] w);
    return w[INT_LSB +: INT_W];
  endfunction

  function automatic logic [PDV_W-1:0] get_pdiv(input logic [31:0] w);
    return w[PDV_LSB +: PDV_W];
  endfunction

  function automatic logic [EXP_W-1:0] get_exp(input logic [31:0] w);
    return w[EXP_LSB +: EXP_W];
  endfunction

  // feedback factor in fixed point: N*2^FRAC_W + F
  function automatic logic [MULT_W-1:0] feedback_word(input logic [31:0] wa);
    return {get_int(wa), get_frac(wa)};
  endfunction

  // full divisor with the fraction scale folded in: D * 2^E * 2^FRAC_W
  function automatic logic [DVS_W-1:0] divisor_word(input logic [31:0] wa,
                                                    input logic [31:0] wb);
    logic [DVS_W-1:0] d;
    d = DVS_W'(get_pdiv(wa));
    d = d << get_exp(wb);
    return d << FRAC_W;
  endfunction

  function automatic logic [OUT_W-1:0] saturate(input logic [DVD_W-1:0] q);
    if (|q[DVD_W-1:OUT_W]) return {OUT_W{1'b1}};
    return q[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/pll_shift_mul.sv
module pll_shift_mul #(
  parameter int A_W = 32,
  parameter int B_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  output logic [A_W+B_W-1:0] product,
  output logic               fin
);
  localparam int P_W = A_W + B_W;
  localparam int CW  = $clog2(B_W);

  logic [P_W-1:0] mcand;
  logic [B_W-1:0] mplier;
  logic [CW-1:0]  cnt;
  logic           run;
  logic           last_step;

  assign last_step = run && (cnt == CW'(B_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      mcand   <= '0;
      mplier  <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        product <= '0;
        mcand   <= P_W'(op_a);
        mplier  <= op_b;
        cnt     <= '0;
        run     <= 1'b1;
      end else if (run) begin
        if (mplier[0]) product <= product + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (last_step) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assert_mul_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(B_W)));
  assert_mul_fin_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !run);
endmodule

// File: rtl/pll_shift_div.sv
module pll_shift_div #(
  parameter int N_W = 59,
  parameter int D_W = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quotient,
  output logic           fin
);
  localparam int CW = $clog2(N_W);

  logic [D_W-1:0] rem;
  logic [D_W-1:0] dvs_q;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [D_W:0]   trial;
  logic [D_W:0]   diff;
  logic           fits;

  assign trial = {rem, quotient[N_W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      dvs_q    <= '0;
      quotient <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem      <= '0;
        dvs_q    <= divisor;
        quotient <= dividend;
        cnt      <= '0;
        run      <= 1'b1;
      end else if (run) begin
        rem      <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        quotient <= {quotient[N_W-2:0], fits};
        cnt      <= cnt + 1'b1;
        if (cnt == CW'(N_W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assert_no_zero_divide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (divisor != '0));
  assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem < dvs_q));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_calc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bypass,
  input  logic [31:0] ref_hz,
  input  logic [31:0] cfg_a,
  input  logic [31:0] cfg_b,
  output logic [31:0] rate_hz,
  output logic        busy,
  output logic        done,
  output logic        err
);
  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DIV, ST_FIN} calc_state_e;

  calc_state_e          state;
  logic                 accept;
  logic                 shortcut;
  logic                 mul_load;
  logic                 mul_fin;
  logic                 div_load;
  logic                 div_fin;
  logic [PROD_W-1:0]    prod;
  logic [DVD_W-1:0]     dividend;
  logic [DVD_W-1:0]     quo;
  logic [DVS_W-1:0]     dvs_q;
  logic [REF_W-1:0]     ref_q;
  logic                 byp_q;

  assign accept   = start && (state == ST_IDLE);
  assign shortcut = bypass || (get_pdiv(cfg_a) == '0);
  assign mul_load = accept && !shortcut;
  assign div_load = (state == ST_MUL) && mul_fin;
  assign dividend = DVD_W'(prod) + DVD_W'(dvs_q >> 1);
  assign busy     = (state != ST_IDLE);

  pll_shift_mul #(.A_W(REF_W), .B_W(MULT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mul_load),
    .op_a    (ref_hz),
    .op_b    (feedback_word(cfg_a)),
    .product (prod),
    .fin     (mul_fin)
  );

  pll_shift_div #(.N_W(DVD_W), .D_W(DVS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (dividend),
    .divisor  (dvs_q),
    .quotient (quo),
    .fin      (div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rate_hz <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      dvs_q   <= '0;
      ref_q   <= '0;
      byp_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ref_q <= ref_hz;
          byp_q <= bypass;
          dvs_q <= divisor_word(cfg_a, cfg_b);
          state <= shortcut ? ST_FIN : ST_MUL;
        end
        ST_MUL: if (mul_fin) state <= ST_DIV;
        ST_DIV: if (div_fin) begin
          rate_hz <= saturate(quo);
          err     <= 1'b0;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: begin
          rate_hz <= byp_q ? ref_q : '0;
          err     <= !byp_q;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_zero_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rate_hz == '0));
  assert_busy_before_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rate_hz) && $stable(err)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_fin && state != ST_FIN) |=> busy);
endmodule

// File: tb/sim_pll_rate_calc.sv
module sim_pll_rate_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bypass = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [31:0] cfg_a = '0;
  logic [31:0] cfg_b = '0;
  logic [31:0] rate_hz;
  logic        busy, done, err;

  int checks = 0;
  int errors = 0;
  localparam int LAT_ARITH = 87;
  localparam int LAT_SHORT = 1;

  always #4 clk = ~clk;

  pll_rate_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
    .ref_hz(ref_hz), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .rate_hz(rate_hz), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {err, rate}
  function automatic logic [32:0] model(input logic [31:0] r, input logic [31:0] a,
                                        input logic [31:0] b, input bit byp);
    longint unsigned num, dv, q, fb;
    if (byp) return {1'b0, r};
    if ((a & 32'h3f) == 0) return {1'b1, 32'h0};
    fb  = (longint'((a >> 6) & 32'h3ff) * 65536) + longint'(a >> 16);
    num = longint'(r) * fb;
    dv  = (longint'(a & 32'h3f) << (b & 32'h7)) * 65536;
    q   = (num + dv / 2) / dv;
    if (q > 64'hFFFF_FFFF) q = 64'hFFFF_FFFF;
    return {1'b0, q[31:0]};
  endfunction

  task automatic run_op(input logic [31:0] r, input logic [31:0] a, input logic [31:0] b,
                        input bit byp, input bit poke, input string req);
    logic [32:0] exp;
    int n;
    bit busy_bad;
    logic [31:0] held;
    exp = model(r, a, b, byp);
    @(negedge clk);
    ref_hz = r; cfg_a = a; cfg_b = b; bypass = byp; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R9: inputs scrambled after the start edge
    ref_hz = $urandom; cfg_a = $urandom; cfg_b = $urandom; bypass = $urandom;
    n = 0; busy_bad = 0;
    while (!done && n < 300) begin
      if (!busy) busy_bad = 1;
      if (poke && n == 5) begin
        start = 1'b1; cfg_a = 32'h0001_0041; ref_hz = 32'd7;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done, {req, " done seen"}, done, 1);
    check(rate_hz == exp[31:0], {req, " rate"}, rate_hz, exp[31:0]);
    check(err == exp[32], {req, " err"}, err, exp[32]);
    check(n == ((byp || exp[32]) ? LAT_SHORT : LAT_ARITH), {req, " R6 latency"}, n,
          (byp || exp[32]) ? LAT_SHORT : LAT_ARITH);
    check(!busy_bad && !busy, {req, " R7 busy window"}, busy, 0);
    held = rate_hz;
    @(negedge clk);
    check(!done && rate_hz == held, {req, " R8 pulse/hold"}, {done, rate_hz}, {1'b0, held});
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !err && rate_hz == 0, "R10 reset", {busy, done, err, rate_hz}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 tie 0.5 -> 1: ref=1, N=0, F=0x8000, D=1, E=0
    run_op(32'd1, {16'h8000, 10'd0, 6'd1}, 32'd0, 0, 0, "R2 tie up");
    // R2 1.5 -> 2: ref=3, N=1, D=2
    run_op(32'd3, {16'h0, 10'd1, 6'd2}, 32'd0, 0, 0, "R2 half");
    // R2 fraction: 24 MHz * (33 + 0.25) / (1*2^2)
    run_op(32'd24_000_000, {16'h4000, 10'd33, 6'd1}, 32'd2, 0, 0, "R2 frac");
    // R1 upper bits of word B ignored
    run_op(32'd24_000_000, {16'h4000, 10'd33, 6'd1}, 32'hFFFF_FFF8 | 32'd2, 0, 0, "R1 wordB");
    // R2 max exponent
    run_op(32'hDEAD_BEEF, {16'hFFFF, 10'd1023, 6'd63}, 32'd7, 0, 0, "R2 emax");
    // R5 saturation
    run_op(32'hFFFF_FFFF, {16'hFFFF, 10'd1023, 6'd1}, 32'd0, 0, 0, "R5 sat");
    // R4 zero pre-divide
    run_op(32'd12345, {16'h1234, 10'd40, 6'd0}, 32'd1, 0, 0, "R4 zero pdiv");
    // R3 bypass, also with zero pre-divide
    run_op(32'd48_000_000, {16'h1, 10'd5, 6'd3}, 32'd1, 1, 0, "R3 bypass");
    run_op(32'd99, {16'h0, 10'd5, 6'd0}, 32'd1, 1, 0, "R3 bypass pdiv0");
    // R9 start while busy ignored
    run_op(32'd25_000_000, {16'h0100, 10'd100, 6'd3}, 32'd1, 0, 1, "R9 ignored");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b, r;
      bit byp;
      r = $urandom;
      a = $urandom;
      b = $urandom;
      byp = (($urandom % 8) == 0);
      if ((a & 32'h3f) == 0 && ($urandom % 4) != 0) a = a | 32'h1;
      run_op(r, a, b, byp, (i % 7) == 3, "R1 R2 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule